// File: doc/BRIEF.md
# Smooth Digital Clock Calibration Unit

This block trims the average rate of a nominal 32768 Hz timebase without plain division. Every input clock cycle normally yields one calendar pulse. Across a repeating calibration window, the block removes a programmed number of pulses and, when asked, adds a fixed number of extra ones. The effective rate therefore moves up or down in small steps while the window counter keeps its own rhythm. Removed pulses are spread through the window and are not bunched together.

The output is a pulse count for each input cycle, carried on two lines. `tick_en` means at least one pulse. `tick_dbl` means a second pulse in the same cycle, which is how an added pulse is delivered. The calendar prescaler that follows adds `tick_en + tick_dbl` every cycle.

The window can be shortened to one half or one quarter of its full length. In low-power mode the window counter advances only on a divided-clock strobe. A new configuration is captured on a write strobe and is applied at the next window boundary. A busy flag covers the time between the write and that boundary.

Top module: `smooth_cal`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `tick_en` and `tick_dbl` are 0. The active configuration resets to zero subtract, no add, full window and normal mode.
- R2: A full window lasts 2^WIN_BITS counting steps. With zero subtract and no add, each cycle delivers exactly one pulse.
- R3: In a full window the subtract value `cfg_sub` (9 bits) removes exactly `cfg_sub` pulses. In each removal cycle `tick_en` is 0.
- R4: The removal cycles are the steps whose window count has its low WIN_BITS-9 bits at zero and whose top 9 bits, bit-reversed, are less than the effective subtract value. No two removal cycles are adjacent.
- R5: With `cfg_add` = 1, 512 extra pulses per full window are delivered as `tick_dbl` cycles, one on each step whose low WIN_BITS-9 count bits are zero. A removal and an insertion in the same cycle cancel to one pulse. Pulses per window = steps + 512*add - sub_eff.
- R6: `cfg_w8` = 1 makes the window 2^(WIN_BITS-2) steps and ignores subtract bits [1:0]. Per window the net change is (512*add - sub_eff)/4.
- R7: `cfg_w16` = 1 (with `cfg_w8` = 0) makes the window 2^(WIN_BITS-1) steps and ignores subtract bit 0. Per window the net change is (512*add - sub_eff)/2.
- R8: If `cfg_w8` and `cfg_w16` are both 1, the quarter-length window of R6 applies.
- R9: With `cfg_lp` = 1 the window counter advances only on cycles where `apre_tick` = 1. Removal and insertion happen only on those cycles. Every other cycle delivers exactly one pulse.
- R10: `cfg_wr` captures all `cfg_*` fields. They take effect at the next window boundary (the step on which the counter wraps). `busy` is 1 from the cycle after the write until that boundary clears it.
- R11: `tick_dbl` is never 1 while `tick_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nominal 32768 Hz input clock |
| rst | input | 1 | Synchronous active-high reset |
| apre_tick | input | 1 | Divided-clock strobe that advances the window in low-power mode |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_sub | input | 9 | Number of pulses removed per full window |
| cfg_add | input | 1 | Adds 512 pulses per full window |
| cfg_w8 | input | 1 | Quarter-length window select |
| cfg_w16 | input | 1 | Half-length window select |
| cfg_lp | input | 1 | Window counter steps on `apre_tick` only |
| busy | output | 1 | Written configuration not yet applied |
| tick_en | output | 1 | At least one calendar pulse this cycle |
| tick_dbl | output | 1 | A second calendar pulse this cycle |

## Verification
The bench builds the block with WIN_BITS = 11. This leaves two low count bits under the 9-bit reversed field, so a full window is 2048 cycles and the quarter window is 512. At that size, complete windows of every length, the low-power mode with a strobe every fourth cycle, and back-to-back reconfigurations all fit in a short run. Pulses are totalled per window against the closed-form count, including the cancelling case of maximum subtract with add set.

// File: rtl/smooth_cal_pkg.sv
package smooth_cal_pkg;

    localparam int CAL_W = 9;

    typedef enum logic [1:0] {
        SPAN_FULL    = 2'd0,
        SPAN_HALF    = 2'd1,
        SPAN_QUARTER = 2'd2
    } span_t;

    typedef struct packed {
        logic [CAL_W-1:0] sub;
        logic             add;
        span_t            span;
        logic             lp;
    } cal_cfg_t;

    typedef struct packed {
        logic remove;
        logic insert;
    } pulse_act_t;

    function automatic span_t pick_span(input logic w8, input logic w16);
        if (w8) begin
            return SPAN_QUARTER;
        end
        if (w16) begin
            return SPAN_HALF;
        end
        return SPAN_FULL;
    endfunction

    function automatic logic [CAL_W-1:0] trim_sub(input logic [CAL_W-1:0] v, input span_t s);
        logic [CAL_W-1:0] keep;
        keep = {CAL_W{1'b1}} << s;
        return v & keep;
    endfunction

    function automatic logic [CAL_W-1:0] rev_field(input logic [CAL_W-1:0] v);
        logic [CAL_W-1:0] r;
        for (int i = 0; i < CAL_W; i++) begin
            r[i] = v[CAL_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/smooth_cal_shadow.sv
module smooth_cal_shadow
    import smooth_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  cal_cfg_t cfg_in,
    input  logic     wrap,
    output cal_cfg_t cfg_act,
    output logic     busy
);

    cal_cfg_t pend_q;
    cal_cfg_t act_q;
    logic     busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (wr) begin
                pend_q <= cfg_in;
            end
            if (wrap) begin
                act_q  <= wr ? cfg_in : pend_q;
                busy_q <= 1'b0;
            end else if (wr) begin
                busy_q <= 1'b1;
            end
        end
    end

    assign cfg_act = act_q;
    assign busy    = busy_q;

endmodule

// File: rtl/smooth_cal_window.sv
module smooth_cal_window
    import smooth_cal_pkg::*;
#(
    parameter int WIN_BITS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  span_t               span,
    output logic [WIN_BITS-1:0] phase,
    output logic                wrap
);

    logic [WIN_BITS-1:0] cnt_q;
    logic [WIN_BITS-1:0] last;

    always_comb begin
        last = {WIN_BITS{1'b1}} >> span;
        wrap = step && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign phase = cnt_q;

endmodule

// File: rtl/smooth_cal_pulse.sv
module smooth_cal_pulse
    import smooth_cal_pkg::*;
#(
    parameter int WIN_BITS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [WIN_BITS-1:0] phase,
    input  cal_cfg_t            cfg_act,
    output logic                tick_en,
    output logic                tick_dbl
);

    localparam int LOW_W = WIN_BITS - CAL_W;

    logic             slot;
    logic [CAL_W-1:0] top_rev;
    pulse_act_t       act;
    logic             en_q;
    logic             dbl_q;

    always_comb begin
        slot       = (phase[LOW_W-1:0] == '0);
        top_rev    = rev_field(phase[WIN_BITS-1 -: CAL_W]);
        act.remove = step && slot && (top_rev < cfg_act.sub);
        act.insert = step && slot && cfg_act.add;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            dbl_q <= 1'b0;
        end else begin
            en_q  <= !(act.remove && !act.insert);
            dbl_q <= act.insert && !act.remove;
        end
    end

    assign tick_en  = en_q;
    assign tick_dbl = dbl_q;

endmodule

// File: rtl/smooth_cal.sv
module smooth_cal
    import smooth_cal_pkg::*;
#(
    parameter int WIN_BITS = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apre_tick,
    input  logic             cfg_wr,
    input  logic [CAL_W-1:0] cfg_sub,
    input  logic             cfg_add,
    input  logic             cfg_w8,
    input  logic             cfg_w16,
    input  logic             cfg_lp,
    output logic             busy,
    output logic             tick_en,
    output logic             tick_dbl
);

    cal_cfg_t            cfg_new;
    cal_cfg_t            cfg_act;
    logic                step;
    logic                win_wrap;
    logic [WIN_BITS-1:0] phase;

    always_comb begin
        cfg_new.span = pick_span(cfg_w8, cfg_w16);
        cfg_new.sub  = trim_sub(cfg_sub, cfg_new.span);
        cfg_new.add  = cfg_add;
        cfg_new.lp   = cfg_lp;
        step         = cfg_act.lp ? apre_tick : 1'b1;
    end

    smooth_cal_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .cfg_in (cfg_new),
        .wrap   (win_wrap),
        .cfg_act(cfg_act),
        .busy   (busy)
    );

    smooth_cal_window #(.WIN_BITS(WIN_BITS)) u_window (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .span (cfg_act.span),
        .phase(phase),
        .wrap (win_wrap)
    );

    smooth_cal_pulse #(.WIN_BITS(WIN_BITS)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .phase   (phase),
        .cfg_act (cfg_act),
        .tick_en (tick_en),
        .tick_dbl(tick_dbl)
    );

endmodule

// File: rtl/smooth_cal_chk.sv
module smooth_cal_chk (
    input logic clk,
    input logic rst,
    input logic cfg_wr,
    input logic busy,
    input logic tick_en,
    input logic tick_dbl,
    input logic step,
    input logic wrap
);

    p_dbl_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        tick_dbl |-> tick_en);

    p_no_adjacent_gap_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> tick_en);

    p_write_raises_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !wrap) |=> busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !wrap) |=> busy);

    p_wrap_clears_busy_r10: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !busy);

    p_idle_step_plain_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> (tick_en && !tick_dbl));

endmodule

bind smooth_cal smooth_cal_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (cfg_wr),
    .busy    (busy),
    .tick_en (tick_en),
    .tick_dbl(tick_dbl),
    .step    (step),
    .wrap    (win_wrap)
);

// File: tb/smooth_cal_test.sv
module smooth_cal_test;

    localparam int W   = 11;
    localparam int LOW = 1 << (W - 9);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       apre_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_sub = '0;
    logic       cfg_add = 1'b0;
    logic       cfg_w8 = 1'b0;
    logic       cfg_w16 = 1'b0;
    logic       cfg_lp = 1'b0;
    logic       busy, tick_en, tick_dbl;

    int checks = 0;
    int fails  = 0;
    int wins   = 0;
    int cyc    = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    smooth_cal #(.WIN_BITS(W)) uut (
        .clk(clk), .rst(rst), .apre_tick(apre_tick), .cfg_wr(cfg_wr),
        .cfg_sub(cfg_sub), .cfg_add(cfg_add), .cfg_w8(cfg_w8),
        .cfg_w16(cfg_w16), .cfg_lp(cfg_lp),
        .busy(busy), .tick_en(tick_en), .tick_dbl(tick_dbl)
    );

    // reference model state
    int m_cnt, m_sub, m_add, m_span, m_lp, m_both;
    int p_sub, p_add, p_span, p_lp, p_both;
    int m_busy, exp_en, exp_dbl, win_cycles, exp_total, win_end, win_tag_both;
    int win_sub, win_add, win_span, win_lp;

    function automatic int rev9(input int v);
        int r = 0;
        for (int i = 0; i < 9; i++) begin
            if ((v >> i) & 1) r = r | (1 << (8 - i));
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sub = 0; m_add = 0; m_span = 0; m_lp = 0; m_both = 0;
            p_sub = 0; p_add = 0; p_span = 0; p_lp = 0; p_both = 0;
            m_busy = 0; exp_en = 0; exp_dbl = 0; win_cycles = 0; win_end = 0;
        end else begin
            int n_sub, n_span, n;
            bit stp, wrapped, rm, ins;
            n_span = cfg_w8 ? 2 : (cfg_w16 ? 1 : 0);
            n_sub  = (int'(cfg_sub) >> n_span) << n_span;
            stp = (m_lp != 0) ? apre_tick : 1'b1;
            rm = 0; ins = 0; wrapped = 0;
            if (stp && (m_cnt % LOW) == 0) begin
                rm  = rev9(m_cnt / LOW) < m_sub;
                ins = (m_add != 0);
            end
            n = 1 + int'(ins) - int'(rm);
            exp_en  = (n >= 1);
            exp_dbl = (n == 2);
            win_cycles++;
            if (stp) begin
                if (m_cnt == (1 << (W - m_span)) - 1) begin
                    wrapped = 1;
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
            if (wrapped) begin
                exp_total = win_cycles + (512 * m_add - m_sub) / (1 << m_span);
                win_sub = m_sub; win_add = m_add; win_span = m_span; win_lp = m_lp;
                win_tag_both = m_both;
                win_end = 1;
                win_cycles = 0;
                if (cfg_wr) begin
                    m_sub = n_sub; m_add = cfg_add; m_span = n_span; m_lp = cfg_lp;
                    m_both = cfg_w8 && cfg_w16;
                end else begin
                    m_sub = p_sub; m_add = p_add; m_span = p_span; m_lp = p_lp;
                    m_both = p_both;
                end
                m_busy = 0;
            end else if (cfg_wr) begin
                m_busy = 1;
            end
            if (cfg_wr) begin
                p_sub = n_sub; p_add = cfg_add; p_span = n_span; p_lp = cfg_lp;
                p_both = cfg_w8 && cfg_w16;
            end
        end
    end

    int obs = 0;
    int prev_en = 1;

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (tick_en !== exp_en[0] || tick_dbl !== exp_dbl[0]) begin
                fails++;
                $display("FAIL R3/R5 per-cycle pulse: en=%0b dbl=%0b expected en=%0b dbl=%0b",
                         tick_en, tick_dbl, exp_en[0], exp_dbl[0]);
            end
            checks++;
            if (busy !== m_busy[0]) begin
                fails++;
                $display("FAIL R10 busy: got %0b expected %0b", busy, m_busy[0]);
            end
            checks++;
            if (tick_dbl && !tick_en) begin
                fails++;
                $display("FAIL R11 dbl without en: got dbl=1 en=0 expected en=1");
            end
            checks++;
            if (prev_en == 0 && tick_en == 0) begin
                fails++;
                $display("FAIL R4 adjacent removals: got en=0 twice expected en=1");
            end
            prev_en = tick_en;
            obs += int'(tick_en) + int'(tick_dbl);
            if (win_end) begin
                win_end = 0;
                checks++;
                if (obs != exp_total) begin
                    fails++;
                    if (win_lp != 0)
                        $display("FAIL R9 window pulses: got %0d expected %0d", obs, exp_total);
                    else if (win_tag_both != 0)
                        $display("FAIL R8 window pulses: got %0d expected %0d", obs, exp_total);
                    else if (win_span == 2)
                        $display("FAIL R6 window pulses: got %0d expected %0d", obs, exp_total);
                    else if (win_span == 1)
                        $display("FAIL R7 window pulses: got %0d expected %0d", obs, exp_total);
                    else if (win_add != 0)
                        $display("FAIL R5 window pulses: got %0d expected %0d", obs, exp_total);
                    else if (win_sub != 0)
                        $display("FAIL R3 window pulses: got %0d expected %0d", obs, exp_total);
                    else
                        $display("FAIL R2 window pulses: got %0d expected %0d", obs, exp_total);
                end
                obs = 0;
                wins++;
            end
        end
    end

    // divided-clock strobe: one cycle in four
    always @(negedge clk) begin
        cyc++;
        apre_tick <= (cyc % 4) == 0;
    end

    task automatic wait_wins(input int n);
        int target = wins + n;
        while (wins < target) @(negedge clk);
    endtask

    task automatic program_cfg(input int sub, input bit add, input bit w8, input bit w16, input bit lp);
        @(negedge clk);
        cfg_sub = sub[8:0]; cfg_add = add; cfg_w8 = w8; cfg_w16 = w16; cfg_lp = lp;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        checks++;
        if (busy !== 1'b1) begin
            fails++;
            $display("FAIL R10 busy after write: got %0b expected 1", busy);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || tick_en !== 1'b0 || tick_dbl !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: got busy=%0b en=%0b dbl=%0b expected 0 0 0",
                     busy, tick_en, tick_dbl);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0) begin
            fails++;
            $display("FAIL R1 busy after reset: got %0b expected 0", busy);
        end
        wait_wins(1);                      // R2: untouched window
        program_cfg(300, 0, 0, 0, 0);  wait_wins(2);   // R3
        program_cfg(0,   1, 0, 0, 0);  wait_wins(2);   // R5
        program_cfg(511, 1, 0, 0, 0);  wait_wins(2);   // R5 with removal overlap
        program_cfg(301, 0, 0, 1, 0);  wait_wins(2);   // R7
        program_cfg(303, 0, 1, 0, 0);  wait_wins(2);   // R6
        program_cfg(303, 1, 1, 0, 0);  wait_wins(2);   // R6 with add
        program_cfg(7,   1, 1, 1, 0);  wait_wins(2);   // R8
        program_cfg(300, 1, 0, 0, 1);  wait_wins(2);   // R9
        program_cfg(0,   0, 0, 0, 0);  wait_wins(2);   // R10 return to plain
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got no completion expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule